// File: doc/BRIEF.md
# Interval Timer Compare Unit

This block gives each processor its own free-running cycle counter and a single 32-bit match register. The counter advances by one on every cycle where the rate enable is high. When the low word of the counter equals the match value during such a cycle, a sticky pending flag is set on the next clock edge. The interrupt line is that flag gated by a software-controlled enable bit. Software arms the next event by writing a new match value. That write also clears the pending flag, so one register access both acknowledges and re-arms the timer.

The counter is either a native double-width counter, or a single-word counter paired with an extension word that counts low-word wraps. Both variants present the same double-width timestamp on the count output. Only the low word is ever compared and nothing reloads automatically. A match value that is already behind the counter therefore fires only after the low word wraps all the way round.

Top module: `interval_match_timer`

## Requirements
- R1: While reset is held low and on the cycle after it, `count_o` is 0 and both `irq_pend_o` and `irq_o` are 0.
- R2: After reset the match register holds all ones, so with no write the pending flag sets on the edge after the low word is counted at its maximum value.
- R3: On an edge where `tick_en` is 1, `count_o` increases by exactly one (modulo its width). On an edge where `tick_en` is 0, it is unchanged.
- R4: A hit is a cycle with `tick_en` 1 and the low LO_W bits of the counter equal to the match register. A hit sets `irq_pend_o` at the next edge, when `count_o` shows the match value plus one. The flag then stays set until it is cleared.
- R5: A match value written behind the counter's low word causes no hit until the low word wraps and reaches it again.
- R6: When CNT_W equals LO_W, the upper half of `count_o` is an extension word. It increments on each edge where the low word steps from all ones to zero. When CNT_W is twice LO_W, `count_o` is a native counter. Both variants give identical `count_o` sequences.
- R7: A write to address 1 loads the interrupt enable from data bit 0, which resets to 0. `irq_o` equals `irq_pend_o` AND the enable. The pending flag still latches while the enable is 0.
- R8: A write to address 0 loads the match register and clears the pending flag. The clear wins over a hit in the same cycle.
- R9: A high `irq_clr` clears the pending flag at the next edge, and wins over a hit in the same cycle.
- R10: A cycle with `tick_en` 0 is never a hit, even while the low word equals the match value.
- R11: Writes to addresses 2 and 3 change neither the match value nor the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Counter rate enable, one step per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address: 0 match value, 1 control |
| reg_wdata | input | LO_W | Write data; bit 0 is the interrupt enable at address 1 |
| irq_clr | input | 1 | Pending flag clear strobe |
| count_o | output | 2*LO_W | Current timestamp |
| irq_o | output | 1 | Maskable interrupt |
| irq_pend_o | output | 1 | Pending flag before the mask |

## Verification
Both counter variants are built with an 8-bit low word and driven with the same stimulus. Any difference in timestamp or flag behaviour separates the extension-word path from the native counter. The stimulus covers:
- a long free run from reset, which exposes the reset match value and the extension carry;
- a match value a few counts ahead, which checks the one-edge hit latency;
- a match value just behind the counter, which shows that no hit comes before the wrap;
- a stalled counter sitting on its match value, which separates an equal value from a counted hit;
- a match write or clear strobe landing on a hit cycle, which checks clear priority;
- writes to the unused addresses and mask toggling with the flag set, which show that the enable and the pending flag are kept apart.

// File: rtl/imt_pkg.sv
// Package: shared constants of the interval timer compare unit.
// Assumes a 2-bit write address space; only two addresses are decoded.
package imt_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_MATCH = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd1;
    localparam int CTRL_IEN_BIT = 0;
endpackage

// File: rtl/imt_counter.sv
// Free-running cycle counter producing a 2*LO_W timestamp.
// Assumes CNT_W is either LO_W (low word plus wrap-count extension) or
// 2*LO_W (native counter). Steps by one when tick_en is high.
module imt_counter #(
    parameter int LO_W  = 32,
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    output logic [LO_W-1:0]   cnt_lo,
    output logic [2*LO_W-1:0] cnt_full
);
    localparam int TS_W = 2 * LO_W;
    localparam logic [LO_W-1:0] LO_ONE = LO_W'(1);
    localparam logic [TS_W-1:0] TS_ONE = TS_W'(1);

    generate
        if (CNT_W == LO_W) begin : g_ext
            logic [LO_W-1:0] lo_q;
            logic [LO_W-1:0] hi_q;

            // Low word counts cycles; the extension counts its wraps.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lo_q <= '0;
                    hi_q <= '0;
                end else if (tick_en) begin
                    lo_q <= lo_q + LO_ONE;
                    if (lo_q == {LO_W{1'b1}}) begin
                        hi_q <= hi_q + LO_ONE;
                    end
                end
            end

            assign cnt_lo   = lo_q;
            assign cnt_full = {hi_q, lo_q};
        end else begin : g_native
            logic [TS_W-1:0] c_q;

            // Native double-width counter.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    c_q <= '0;
                end else if (tick_en) begin
                    c_q <= c_q + TS_ONE;
                end
            end

            assign cnt_lo   = c_q[LO_W-1:0];
            assign cnt_full = c_q;
        end
    endgenerate
endmodule

// File: rtl/imt_match.sv
// Match register and equality detector.
// Assumes only the low word of the counter is compared; resets to all ones.
// A hit needs an enabled cycle, so a stalled counter never re-hits.
module imt_match #(
    parameter int LO_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic [LO_W-1:0] cnt_lo,
    input  logic            match_we,
    input  logic [LO_W-1:0] match_wdata,
    output logic            hit
);
    logic [LO_W-1:0] match_q;

    // Hold the software-written match value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= {LO_W{1'b1}};
        end else if (match_we) begin
            match_q <= match_wdata;
        end
    end

    // Equality in a counted cycle is a hit.
    always_comb begin
        hit = tick_en && (cnt_lo == match_q);
    end
endmodule

// File: rtl/imt_irq.sv
// Pending flag and interrupt enable.
// Assumes clear has priority over a same-cycle hit; the flag latches
// independently of the enable.
module imt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic pend_clr,
    input  logic ien_we,
    input  logic ien_wdata,
    output logic pend,
    output logic irq
);
    logic pend_q;
    logic ien_q;

    // Sticky pending flag, cleared by strobe or match write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (pend_clr) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end
    end

    // Interrupt enable bit, masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (ien_we) begin
            ien_q <= ien_wdata;
        end
    end

    assign pend = pend_q;
    assign irq  = pend_q & ien_q;
endmodule

// File: rtl/interval_match_timer.sv
// Interval timer compare unit top level.
// Decodes the small write port, ties the counter, matcher and flag logic.
// Assumes CNT_W is LO_W or 2*LO_W; count_o is always 2*LO_W wide.
module interval_match_timer
    import imt_pkg::*;
#(
    parameter int LO_W  = 32,
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LO_W-1:0]   reg_wdata,
    input  logic              irq_clr,
    output logic [2*LO_W-1:0] count_o,
    output logic              irq_o,
    output logic              irq_pend_o
);
    logic [LO_W-1:0] cnt_lo;
    logic            hit;
    logic            match_we;
    logic            ctrl_we;
    logic            pend_clr;

    // Write decode; unused addresses fall through with no effect.
    always_comb begin
        match_we = reg_wr && (reg_addr == ADDR_MATCH);
        ctrl_we  = reg_wr && (reg_addr == ADDR_CTRL);
        pend_clr = irq_clr || match_we;
    end

    imt_counter #(.LO_W(LO_W), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .cnt_lo   (cnt_lo),
        .cnt_full (count_o)
    );

    imt_match #(.LO_W(LO_W)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .cnt_lo      (cnt_lo),
        .match_we    (match_we),
        .match_wdata (reg_wdata),
        .hit         (hit)
    );

    imt_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .pend_clr  (pend_clr),
        .ien_we    (ctrl_we),
        .ien_wdata (reg_wdata[CTRL_IEN_BIT]),
        .pend      (irq_pend_o),
        .irq       (irq_o)
    );
endmodule

// File: rtl/imt_checker.sv
// Port-level property checker for the interval timer compare unit.
// Attached to every instance of the top through the bind below.
module imt_checker #(
    parameter int LO_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic              irq_clr,
    input logic [2*LO_W-1:0] count_o,
    input logic              irq_o,
    input logic              irq_pend_o
);
    localparam logic [2*LO_W-1:0] TS_ONE = (2*LO_W)'(1);

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0) && !irq_pend_o && !irq_o); // R1

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && tick_en) |=> count_o == $past(count_o) + TS_ONE); // R3

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !tick_en) |=> $stable(count_o)); // R3

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && irq_pend_o && !irq_clr && !(reg_wr && reg_addr == 2'd0))
        |=> irq_pend_o); // R4

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_pend_o); // R7

    AST_MATCH_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && reg_wr && reg_addr == 2'd0) |=> !irq_pend_o); // R8

    AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && irq_clr) |=> !irq_pend_o); // R9

    AST_NO_STALL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !irq_pend_o && !tick_en) |=> !irq_pend_o); // R10
endmodule

bind interval_match_timer imt_checker #(.LO_W(LO_W)) u_imt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .irq_clr    (irq_clr),
    .count_o    (count_o),
    .irq_o      (irq_o),
    .irq_pend_o (irq_pend_o)
);

// File: tb/interval_match_timer_tb_top.sv
// Scoreboard bench: two narrow instances (extension-word and native
// counter) share the stimulus and must both match one reference model.
module interval_match_timer_tb_top;
    localparam int LO_W = 8;
    localparam int TS_W = 2 * LO_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick_en = 1'b0;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_addr = 2'd0;
    logic [LO_W-1:0] reg_wdata = '0;
    logic            irq_clr = 1'b0;

    logic [TS_W-1:0] cnt_a, cnt_b;
    logic            irq_a, irq_b, pend_a, pend_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [TS_W-1:0] cnt;
        logic            pend;
        logic            irq;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    // Reference model state
    logic [TS_W-1:0] m_cnt;
    logic [LO_W-1:0] m_cmp;
    logic            m_pend;
    logic            m_ien;

    always #4 clk = ~clk;

    interval_match_timer #(.LO_W(LO_W), .CNT_W(LO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_clr(irq_clr),
        .count_o(cnt_a), .irq_o(irq_a), .irq_pend_o(pend_a)
    );

    interval_match_timer #(.LO_W(LO_W), .CNT_W(TS_W)) dut_w_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_clr(irq_clr),
        .count_o(cnt_b), .irq_o(irq_b), .irq_pend_o(pend_b)
    );

    task automatic cmp_one(input string who, input string tag,
                           input logic [TS_W-1:0] c, input logic p, input logic i,
                           input exp_t e);
        n_chk++;
        if (c !== e.cnt || p !== e.pend || i !== e.irq) begin
            n_fail++;
            $display("FAIL %s %s: count=%h pend=%b irq=%b expected count=%h pend=%b irq=%b",
                     tag, who, c, p, i, e.cnt, e.pend, e.irq);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input logic en, input logic wr, input logic [1:0] addr,
                        input logic [LO_W-1:0] data, input logic clr, input string tag);
        logic hit, mwe;
        exp_t e;
        @(negedge clk);
        tick_en = en; reg_wr = wr; reg_addr = addr; reg_wdata = data; irq_clr = clr;
        mwe = wr && (addr == 2'd0);
        hit = en && (m_cnt[LO_W-1:0] == m_cmp);
        if (clr || mwe) m_pend = 1'b0;
        else if (hit)   m_pend = 1'b1;
        if (mwe) m_cmp = data;
        if (wr && addr == 2'd1) m_ien = data[0];
        if (en) m_cnt = m_cnt + TS_W'(1);
        e.cnt = m_cnt; e.pend = m_pend; e.irq = m_pend & m_ien;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1'b1, 1'b0, 2'd0, '0, 1'b0, tag);
    endtask

    // Monitor: compare both instances after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                cmp_one("dut_i",   t, cnt_a, pend_a, irq_a, e);
                cmp_one("dut_w_i", t, cnt_b, pend_b, irq_b, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t r;
        m_cnt = '0; m_cmp = '1; m_pend = 1'b0; m_ien = 1'b0;
        r.cnt = '0; r.pend = 1'b0; r.irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp_one("dut_i",   "R1", cnt_a, pend_a, irq_a, r);
        cmp_one("dut_w_i", "R1", cnt_b, pend_b, irq_b, r);
        rst_n = 1'b1;

        // Free run from reset: default match and extension carry
        run(300, "R2 R3 R6");
        step(1'b0, 1'b0, 2'd0, '0, 1'b1, "R9");
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 2'd0, '0, 1'b0, "R3");

        // Enable and arm a few counts ahead
        step(1'b1, 1'b1, 2'd1, 8'h01, 1'b0, "R7");
        step(1'b1, 1'b1, 2'd0, m_cnt[LO_W-1:0] + 8'd6, 1'b0, "R4");
        run(10, "R4 R7");

        // Stalled on the match value
        step(1'b0, 1'b1, 2'd0, m_cnt[LO_W-1:0], 1'b0, "R10");
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 2'd0, '0, 1'b0, "R10");
        step(1'b1, 1'b0, 2'd0, '0, 1'b0, "R10");
        run(2, "R10");

        // Match value behind the counter
        step(1'b1, 1'b1, 2'd0, m_cnt[LO_W-1:0] - 8'd3, 1'b0, "R5");
        run(260, "R5 R6");

        // Clear priority over a same-cycle hit
        step(1'b0, 1'b1, 2'd0, m_cnt[LO_W-1:0], 1'b0, "R8");
        step(1'b1, 1'b1, 2'd0, m_cnt[LO_W-1:0] + 8'd100, 1'b0, "R8");
        step(1'b0, 1'b1, 2'd0, m_cnt[LO_W-1:0], 1'b0, "R9");
        step(1'b1, 1'b0, 2'd0, '0, 1'b1, "R9");
        run(3, "R8 R9");
        step(1'b1, 1'b1, 2'd0, m_cnt[LO_W-1:0] + 8'd90, 1'b0, "R4");

        // Unused addresses leave match and enable alone
        step(1'b1, 1'b1, 2'd2, 8'h00, 1'b0, "R11");
        step(1'b1, 1'b1, 2'd3, 8'h00, 1'b0, "R11");
        run(110, "R11 R4");

        // Mask with the flag set
        step(1'b1, 1'b1, 2'd1, 8'h00, 1'b0, "R7");
        run(3, "R7");
        step(1'b1, 1'b1, 2'd1, 8'h01, 1'b0, "R7");
        run(2, "R7");

        step(1'b0, 1'b0, 2'd0, '0, 1'b0, "R3");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule